// File: doc/BRIEF.md
# PS/2 Frame Transceiver

This block is the serial engine for a single keyboard or pointing-device channel. It moves one byte at a time over a two-wire open-drain link in which the attached device generates the clock. It never drives a line high. It only pulls the clock or data line low through an enable output, or lets it float. Both line inputs pass through a synchronizer before any logic uses them. Falling edges of the synchronized clock are the only sampling points.

In the receive direction, the block collects a frame from the device, checks its parity and presents the byte with a one-cycle strobe. In the transmit direction, the block takes a byte from a single-cycle request and first holds the clock low to inhibit the device. It then places a start bit and shifts the byte out on the device's clock. It then waits for the device to pull data low as an acknowledge. No new byte is accepted until that acknowledge arrives or the transmit time limit expires.

A frame that stalls part-way through is abandoned and reported. Every error is reported as a single-cycle flag, so the surrounding controller can latch whatever status it keeps.

Top module: `ps2_link_engine`

## Requirements
- R1: While reset is asserted, and whenever no transmission is in progress, `ps2_clk_oe` and `ps2_dat_oe` are 0, so both lines are released. After reset, `tx_busy`, `tx_done`, `rx_valid`, `err_parity`, `err_tx_timeout` and `err_rx_timeout` are all 0.
- R2: A frame sent by the device is received in this order: start bit 0, data bit 0 through data bit 7 (least significant first), parity bit, stop bit. Each bit is sampled on a falling edge of the synchronized clock. After the stop-bit edge, `rx_valid` is high for exactly one cycle, and `rx_byte` then holds the eight data bits.
- R3: Parity is odd. `err_parity` is 1 in the `rx_valid` cycle exactly when the eight data bits plus the parity bit contain an even number of ones. At all other times it is 0.
- R4: When no frame is being received, a falling clock edge that finds the data line high is not taken as a start bit. It has no effect on the next frame received.
- R5: If a frame being received sees no falling clock edge for `RX_STALL_CYC` consecutive cycles, the frame is dropped without an `rx_valid`. `err_rx_timeout` pulses for one cycle, and the next complete frame is received normally.
- R6: When a transmit request is accepted, `ps2_clk_oe` is 1 for exactly `INHIBIT_CYC` cycles while `ps2_dat_oe` stays 0. In the cycle `ps2_clk_oe` returns to 0, `ps2_dat_oe` becomes 1, which forms the start bit.
- R7: After the start bit, each falling clock edge presents the next bit on the data line: data bit 0 through data bit 7, then the odd parity bit, then a released (high) stop bit. A 0 bit is driven as `ps2_dat_oe` = 1.
- R8: After the stop bit, the first falling clock edge that finds the data line low is taken as the acknowledge. `tx_done` pulses for one cycle, and `tx_busy` is 0 in that cycle. `tx_busy` only falls together with `tx_done` or `err_tx_timeout`.
- R9: A transmit request made while `tx_busy` is 1 is ignored. The byte in flight is not changed, and no second transmission follows.
- R10: If the acknowledge has not arrived `TX_LIMIT_CYC` cycles after a request was accepted, `err_tx_timeout` pulses for one cycle. Both lines are released and `tx_busy` goes to 0.
- R11: While `tx_busy` is 1, the receiver is disabled: no `rx_valid` and no `err_rx_timeout` are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Clock line as seen at the pin, not yet synchronized |
| ps2_dat_i | input | 1 | Data line as seen at the pin, not yet synchronized |
| tx_req | input | 1 | Single-cycle request to send `tx_byte` |
| tx_byte | input | 8 | Byte to send, captured when the request is accepted |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| tx_busy | output | 1 | A transmission is in progress |
| tx_done | output | 1 | One-cycle pulse when the device acknowledge is seen |
| err_tx_timeout | output | 1 | One-cycle pulse when a transmission is abandoned |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last received byte |
| err_parity | output | 1 | Parity failure, valid in the `rx_valid` cycle |
| err_rx_timeout | output | 1 | One-cycle pulse when a stalled receive frame is dropped |

## Verification
The bench builds the block with `INHIBIT_CYC` = 40, `TX_LIMIT_CYC` = 1500 and `RX_STALL_CYC` = 200, and its device model uses a 20-cycle line clock. With these values, both the stalled-frame abort and the transmit timeout happen within a few hundred to about fifteen hundred cycles, instead of the hundreds of thousands of cycles that real link timing would need. The exact inhibit length can also be counted cycle by cycle. The device clock is slow enough relative to the synchronizer latency that the data timing on both sides is exercised without a race at any sampling edge.

// File: rtl/ps2x_pkg.sv
package ps2x_pkg;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_INHIBIT,
      TX_SHIFT,
      TX_ACK
   } tx_state_e;

   // Bit that makes the total count of ones in {par, b} odd.
   function automatic logic odd_par(input logic [7:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/ps2x_sync.sv
module ps2x_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ps2x_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   // Idle lines float high, so reset loads ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '1;
      end else begin
         pipe_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/ps2x_rx.sv
module ps2x_rx #(
   parameter int STALL_CYC = 125000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       fall,
   input  logic       line_dat,
   output logic       valid,
   output logic [7:0] data,
   output logic       perr,
   output logic       stall_err
);

   localparam int SW = $clog2(STALL_CYC + 1);

   if (STALL_CYC < 2) begin : g_bad_stall
      $error("ps2x_rx: STALL_CYC must be at least 2");
   end

   logic          active_q;
   logic [3:0]    idx_q;    // next bit index, 1..10
   logic [8:0]    shift_q;  // parity in [8], data bit 0 in [0] when full
   logic [SW-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         idx_q     <= '0;
         shift_q   <= '0;
         quiet_q   <= '0;
         valid     <= 1'b0;
         data      <= '0;
         perr      <= 1'b0;
         stall_err <= 1'b0;
      end else begin
         valid     <= 1'b0;
         perr      <= 1'b0;
         stall_err <= 1'b0;
         if (!enable) begin
            active_q <= 1'b0;
            quiet_q  <= '0;
         end else if (fall) begin
            quiet_q <= '0;
            if (!active_q) begin
               if (!line_dat) begin
                  active_q <= 1'b1;
                  idx_q    <= 4'd1;
               end
            end else if (idx_q == 4'd10) begin
               active_q <= 1'b0;
               valid    <= 1'b1;
               data     <= shift_q[7:0];
               perr     <= ~(^shift_q);
            end else begin
               shift_q <= {line_dat, shift_q[8:1]};
               idx_q   <= idx_q + 4'd1;
            end
         end else if (active_q) begin
            if (quiet_q == SW'(STALL_CYC - 1)) begin
               active_q  <= 1'b0;
               stall_err <= 1'b1;
               quiet_q   <= '0;
            end else begin
               quiet_q <= quiet_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ps2x_tx.sv
module ps2x_tx
   import ps2x_pkg::*;
#(
   parameter int INHIBIT_CYC = 12500,
   parameter int LIMIT_CYC   = 250000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] byte_in,
   input  logic       fall,
   input  logic       line_dat,
   output logic       clk_oe,
   output logic       dat_oe,
   output logic       busy,
   output logic       done,
   output logic       timeout
);

   localparam int IW      = $clog2(INHIBIT_CYC + 1);
   localparam int LW      = $clog2(LIMIT_CYC + 1);
   localparam int FRAME_W = 10;   // data, parity, stop

   tx_state_e           state_q;
   logic [IW-1:0]       inh_q;
   logic [LW-1:0]       lim_q;
   logic [FRAME_W-1:0]  frame_q;
   logic [3:0]          sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         inh_q   <= '0;
         lim_q   <= '0;
         frame_q <= '1;
         sent_q  <= '0;
         clk_oe  <= 1'b0;
         dat_oe  <= 1'b0;
         done    <= 1'b0;
         timeout <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= 1'b0;
         if (state_q == TX_IDLE) begin
            if (req) begin
               frame_q <= {1'b1, odd_par(byte_in), byte_in};
               inh_q   <= '0;
               lim_q   <= '0;
               clk_oe  <= 1'b1;
               dat_oe  <= 1'b0;
               state_q <= TX_INHIBIT;
            end
         end else if (state_q == TX_ACK && fall && !line_dat) begin
            done    <= 1'b1;
            clk_oe  <= 1'b0;
            dat_oe  <= 1'b0;
            state_q <= TX_IDLE;
         end else if (lim_q == LW'(LIMIT_CYC - 1)) begin
            timeout <= 1'b1;
            clk_oe  <= 1'b0;
            dat_oe  <= 1'b0;
            state_q <= TX_IDLE;
         end else begin
            lim_q <= lim_q + 1'b1;
            case (state_q)
               TX_INHIBIT: begin
                  if (inh_q == IW'(INHIBIT_CYC - 1)) begin
                     clk_oe  <= 1'b0;
                     dat_oe  <= 1'b1;      // start bit
                     sent_q  <= '0;
                     state_q <= TX_SHIFT;
                  end else begin
                     inh_q <= inh_q + 1'b1;
                  end
               end
               TX_SHIFT: begin
                  if (fall) begin
                     dat_oe  <= ~frame_q[0];
                     frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                     sent_q  <= sent_q + 4'd1;
                     if (sent_q == 4'(FRAME_W - 1)) begin
                        state_q <= TX_ACK;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign busy = (state_q != TX_IDLE);

endmodule

// File: rtl/ps2_link_engine.sv
module ps2_link_engine #(
   parameter int SYNC_STAGES  = 2,
   parameter int INHIBIT_CYC  = 12500,
   parameter int TX_LIMIT_CYC = 250000,
   parameter int RX_STALL_CYC = 125000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   input  logic       tx_req,
   input  logic [7:0] tx_byte,
   output logic       ps2_clk_oe,
   output logic       ps2_dat_oe,
   output logic       tx_busy,
   output logic       tx_done,
   output logic       err_tx_timeout,
   output logic       rx_valid,
   output logic [7:0] rx_byte,
   output logic       err_parity,
   output logic       err_rx_timeout
);

   if (INHIBIT_CYC < 1) begin : g_bad_inhibit
      $error("ps2_link_engine: INHIBIT_CYC must be at least 1");
   end
   if (TX_LIMIT_CYC <= INHIBIT_CYC) begin : g_bad_limit
      $error("ps2_link_engine: TX_LIMIT_CYC must exceed INHIBIT_CYC");
   end

   logic [1:0] line_s;
   logic       clk_prev_q;
   logic       clk_fall;

   ps2x_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ps2_dat_i, ps2_clk_i}),
      .q     (line_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev_q <= 1'b1;
      else        clk_prev_q <= line_s[0];
   end

   assign clk_fall = clk_prev_q & ~line_s[0];

   ps2x_tx #(.INHIBIT_CYC(INHIBIT_CYC), .LIMIT_CYC(TX_LIMIT_CYC)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (tx_req),
      .byte_in  (tx_byte),
      .fall     (clk_fall),
      .line_dat (line_s[1]),
      .clk_oe   (ps2_clk_oe),
      .dat_oe   (ps2_dat_oe),
      .busy     (tx_busy),
      .done     (tx_done),
      .timeout  (err_tx_timeout)
   );

   ps2x_rx #(.STALL_CYC(RX_STALL_CYC)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (~tx_busy),
      .fall      (clk_fall),
      .line_dat  (line_s[1]),
      .valid     (rx_valid),
      .data      (rx_byte),
      .perr      (err_parity),
      .stall_err (err_rx_timeout)
   );

endmodule

// File: rtl/ps2_link_engine_chk.sv
module ps2_link_engine_chk #(
   parameter int INHIBIT_CYC = 12500
) (
   input logic clk,
   input logic rst_n,
   input logic ps2_clk_oe,
   input logic ps2_dat_oe,
   input logic tx_busy,
   input logic tx_done,
   input logic err_tx_timeout,
   input logic rx_valid,
   input logic err_parity,
   input logic err_rx_timeout
);

   localparam int CW = $clog2(INHIBIT_CYC + 2);

   logic [CW-1:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run_q <= '0;
      else if (ps2_clk_oe) low_run_q <= low_run_q + 1'b1;
      else                 low_run_q <= '0;
   end

   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (!ps2_clk_oe && !ps2_dat_oe));

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_perr_in_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_parity |-> rx_valid);

   p_stall_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_rx_timeout |-> (!rx_valid ##1 !err_rx_timeout));

   p_inhibit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_oe) |-> (low_run_q == CW'(INHIBIT_CYC) && ps2_dat_oe));

   p_busy_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> (tx_done || err_tx_timeout));

   p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (!err_tx_timeout && !tx_busy));

   p_txto_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_tx_timeout |-> (!tx_busy && !ps2_clk_oe && !ps2_dat_oe));

   p_quiet_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> (!rx_valid && !err_rx_timeout));

endmodule

bind ps2_link_engine ps2_link_engine_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (.*);

// File: tb/tb_ps2_link_engine.sv
module tb_ps2_link_engine;

   localparam int INH   = 40;
   localparam int LIM   = 1500;
   localparam int STALL = 200;
   localparam int H     = 10;   // device half clock, in system cycles

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       dev_clk_low = 1'b0;
   logic       dev_dat_low = 1'b0;
   logic       tx_req = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       ps2_clk_oe, ps2_dat_oe, tx_busy, tx_done, err_tx_timeout;
   logic       rx_valid, err_parity, err_rx_timeout;
   logic [7:0] rx_byte;
   logic       line_clk, line_dat;

   assign line_clk = !(ps2_clk_oe || dev_clk_low);
   assign line_dat = !(ps2_dat_oe || dev_dat_low);

   ps2_link_engine #(
      .SYNC_STAGES(2), .INHIBIT_CYC(INH), .TX_LIMIT_CYC(LIM), .RX_STALL_CYC(STALL)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
      .tx_req(tx_req), .tx_byte(tx_byte), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
      .tx_busy(tx_busy), .tx_done(tx_done), .err_tx_timeout(err_tx_timeout),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .err_parity(err_parity),
      .err_rx_timeout(err_rx_timeout)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [8:0] exp_rx[$];
   int exp_rx_to = 0;
   int exp_tx_to = 0;
   int exp_done = 0;
   int rx_seen = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Reference model: expected events queued by the stimulus, compared every clock.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            rx_seen++;
            if (exp_rx.size() == 0) begin
               chk(1'b0, "R2 unexpected received byte", {23'd0, err_parity, rx_byte}, 0);
            end else begin
               logic [8:0] e;
               e = exp_rx.pop_front();
               chk({err_parity, rx_byte} == e, "R2/R3 received byte and parity flag",
                   {23'd0, err_parity, rx_byte}, {23'd0, e});
            end
         end
         if (!rx_valid && err_parity) chk(1'b0, "R3 parity flag outside strobe", 1, 0);
         if (err_rx_timeout) begin
            chk(exp_rx_to > 0, "R5 receive timeout expected", 1, exp_rx_to);
            if (exp_rx_to > 0) exp_rx_to--;
         end
         if (err_tx_timeout) begin
            chk(exp_tx_to > 0, "R10 transmit timeout expected", 1, exp_tx_to);
            if (exp_tx_to > 0) exp_tx_to--;
         end
         if (tx_done) begin
            chk(exp_done > 0, "R8 done pulse expected", 1, exp_done);
            if (exp_done > 0) exp_done--;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dev_send(input logic [7:0] b, input bit flip, input int nbits);
      logic [10:0] f;
      f = {1'b1, (~(^b)) ^ flip, b, 1'b0};
      for (int i = 0; i < nbits; i++) begin
         dev_dat_low = ~f[i];
         cyc(H);
         dev_clk_low = 1'b1;
         cyc(H);
         dev_clk_low = 1'b0;
      end
      dev_dat_low = 1'b0;
      cyc(H + 5);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit flip);
      exp_rx.push_back({flip, b});
      dev_send(b, flip, 11);
   endtask

   task automatic host_req(input logic [7:0] b);
      tx_req = 1'b1;
      tx_byte = b;
      cyc(1);
      tx_req = 1'b0;
   endtask

   task automatic dev_recv(input bit ack, output logic [10:0] got, output int inh_n,
                           output logic start_low);
      inh_n = 0;
      got = '0;
      while (!ps2_clk_oe) cyc(1);
      while (ps2_clk_oe) begin
         inh_n++;
         cyc(1);
      end
      start_low = ps2_dat_oe;
      cyc(H);
      for (int k = 1; k <= 10; k++) begin
         dev_clk_low = 1'b1;
         cyc(H);
         got[k] = line_dat;
         dev_clk_low = 1'b0;
         cyc(H);
      end
      if (ack) begin
         dev_dat_low = 1'b1;
         cyc(2);
         dev_clk_low = 1'b1;
         cyc(H);
         dev_clk_low = 1'b0;
         cyc(H);
         dev_dat_low = 1'b0;
      end
      cyc(5);
   endtask

   task automatic tx_case(input logic [7:0] b);
      logic [10:0] g;
      int n;
      logic s;
      int seen0;
      seen0 = rx_seen;
      exp_done++;
      host_req(b);
      dev_recv(1'b1, g, n, s);
      chk(n == INH, "R6 clock inhibit length", n, INH);
      chk(s == 1'b1, "R6 start bit driven low", {31'd0, s}, 1);
      chk(g[8:1] == b, "R7 data bits least significant first", {24'd0, g[8:1]}, {24'd0, b});
      chk(g[9] == ~(^b), "R7 odd parity bit", {31'd0, g[9]}, {31'd0, ~(^b)});
      chk(g[10] == 1'b1, "R7 stop bit released", {31'd0, g[10]}, 1);
      chk(exp_done == 0, "R8 done after acknowledge", exp_done, 0);
      chk(!tx_busy, "R8 busy cleared after acknowledge", {31'd0, tx_busy}, 0);
      chk(rx_seen == seen0, "R11 no receive during transmit", rx_seen, seen0);
   endtask

   initial begin
      cyc(10);
      chk(!ps2_clk_oe && !ps2_dat_oe, "R1 lines released in reset", {30'd0, ps2_clk_oe, ps2_dat_oe}, 0);
      rst_n = 1'b1;
      cyc(5);
      chk({ps2_clk_oe, ps2_dat_oe, tx_busy, tx_done, err_tx_timeout, rx_valid, err_parity,
           err_rx_timeout} == 8'h00, "R1 outputs idle after reset",
          {24'd0, ps2_clk_oe, ps2_dat_oe, tx_busy, tx_done, err_tx_timeout, rx_valid,
           err_parity, err_rx_timeout}, 0);

      // R2: several byte patterns with good parity
      send_frame(8'hA5, 1'b0);
      send_frame(8'h3C, 1'b0);
      send_frame(8'h00, 1'b0);
      send_frame(8'hFF, 1'b0);
      // R3: corrupted parity
      send_frame(8'h5A, 1'b1);
      send_frame(8'h01, 1'b1);

      // R4: a clock pulse with data high while idle must not start a frame
      dev_dat_low = 1'b0;
      dev_clk_low = 1'b1;
      cyc(H);
      dev_clk_low = 1'b0;
      cyc(H);
      send_frame(8'h81, 1'b0);
      chk(exp_rx.size() == 0, "R4 frame after stray edge received intact", exp_rx.size(), 0);

      // R5: partial frame then silence
      exp_rx_to++;
      dev_send(8'h77, 1'b0, 4);
      cyc(STALL + 50);
      chk(exp_rx_to == 0, "R5 stalled frame reported", exp_rx_to, 0);
      send_frame(8'h12, 1'b0);
      chk(exp_rx.size() == 0, "R5 next frame after stall received", exp_rx.size(), 0);

      // R6, R7, R8, R11: transmissions
      tx_case(8'hC3);
      tx_case(8'h01);
      tx_case(8'hFE);

      // R9: request while busy is ignored
      begin
         logic [10:0] g;
         int n;
         logic s;
         exp_done++;
         host_req(8'h96);
         fork
            dev_recv(1'b1, g, n, s);
            begin
               cyc(150);
               tx_req = 1'b1;
               tx_byte = 8'h11;
               cyc(1);
               tx_req = 1'b0;
            end
         join
         chk(g[8:1] == 8'h96, "R9 byte in flight unchanged", {24'd0, g[8:1]}, 32'h96);
         cyc(300);
         chk(!tx_busy && !ps2_clk_oe && !ps2_dat_oe, "R9 no second transmission",
             {29'd0, tx_busy, ps2_clk_oe, ps2_dat_oe}, 0);
      end

      // R10: device never clocks, transmit times out
      exp_tx_to++;
      host_req(8'h44);
      cyc(LIM + 50);
      chk(exp_tx_to == 0, "R10 transmit timeout reported", exp_tx_to, 0);
      chk(!tx_busy && !ps2_clk_oe && !ps2_dat_oe, "R10 lines released after timeout",
          {29'd0, tx_busy, ps2_clk_oe, ps2_dat_oe}, 0);

      // receive works again after transmit activity
      send_frame(8'h5C, 1'b0);
      chk(exp_rx.size() == 0 && exp_done == 0, "R2 all expected events seen",
          exp_rx.size() + exp_done, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired before the sequence completed");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule